// File: doc/BRIEF.md
# Glitch-Tolerant Gray-Code Clock Receiver

This block recovers a shared bus clock that is sent as a Gray-coded count over several wires. On a backplane whose wiring is not controlled, reflections can make those wires bounce for a while after each transition. The receiver keeps the last Gray code it accepted and works out the one code that must come next. It moves forward only when the synchronized bus word is exactly that code. A bounce back to the older code, or any other unexpected pattern, leaves its state unchanged.

Each bus bit passes through its own multi-stage synchronizer into a fast local clock domain. The accepted count is given as a binary number. Its lowest bit toggles on every accepted step and serves as the recovered clock. The upper bits form a cycle counter for the bus logic. A one-cycle pulse marks the local cycle in which a new code is taken. With a width of two wires the block works as a pure clock receiver.

Top module: `gray_clock_rx`

## Requirements
- R1: While reset is asserted and right after it, `count_bin` is zero, `bus_clk` is 0 and `step` is 0.
- R2: When `bus_gray` changes to the Gray code of (count+1) and then holds, `count_bin` equals count+1 after the third rising clock edge that follows the change. The Gray code of n is n XOR (n >> 1).
- R3: When `bus_gray` returns to the Gray code of the previous count, or stays on the current code, `count_bin` does not change and `step` stays 0.
- R4: Any bus word other than the expected next Gray code is ignored, including a code two steps ahead.
- R5: `bus_clk` always equals bit 0 of `count_bin`, so it toggles once per accepted step.
- R6: `step` is high for exactly one clock cycle per accepted code, in the cycle in which `count_bin` shows the new value.
- R7: After the all-ones count, the next code accepted is the Gray code of zero, and the count wraps to 0.
- R8: The bus width `WIDTH` is a parameter with a minimum of 2. The behaviour in R2 to R7 holds for both WIDTH=2 and WIDTH=4.
- R9: The bus word reaches the comparator only through `SYNC_STAGES` (default 2) flip-flops per bit. After only two rising edges following a change, `count_bin` still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast local sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_gray | input | WIDTH | Gray-coded bus clock wires, asynchronous to clk |
| count_bin | output | WIDTH | Accepted count in binary |
| bus_clk | output | 1 | Recovered bus clock, the lowest count bit |
| step | output | 1 | One-cycle pulse on each accepted code |

## Verification
The assertions assume that each bus code stays stable for well over the synchronizer depth plus one local cycle. This means any bounce has died out before the transmitter moves to the following code. Under that assumption, at most one bit changes between successive synchronized words and steps never occur on back-to-back cycles. The stimulus drives every code on the falling clock edge and holds it for at least five local cycles. Bounces and wrong codes are likewise held steady for several cycles before the correct code is driven. So the synchronized word never skips a code the receiver is waiting for.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
   // smallest legal bus width (pure clock, no counter bits)
   localparam int GCR_MIN_WIDTH  = 2;
   // smallest synchronizer depth accepted
   localparam int GCR_MIN_STAGES = 2;
endpackage

// File: rtl/gcr_sync.sv
module gcr_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   import gcr_pkg::*;

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < GCR_MIN_STAGES) begin : g_bad_stages
         $error("gcr_sync: STAGES below minimum");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[k] <= '0;
               else        chain[k] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[k] <= '0;
               else        chain[k] <= chain[k-1];
            end

            // R9
            stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
               chain[k] == $past(chain[k-1]))
               else $error("synchronizer stage %0d did not shift", k);
         end
      end
   endgenerate

   assign sync_out = chain[LAST];
endmodule

// File: rtl/gcr_next.sv
module gcr_next #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] gray_cur,
   output logic [WIDTH-1:0] gray_nxt,
   output logic [WIDTH-1:0] bin_nxt
);
   localparam int TOP = WIDTH - 1;

   logic [WIDTH-1:0] bin_cur;

   // Gray to binary: prefix XOR from the most significant bit down
   assign bin_cur[TOP] = gray_cur[TOP];
   generate
      for (genvar i = TOP - 1; i >= 0; i--) begin : g_g2b
         assign bin_cur[i] = bin_cur[i+1] ^ gray_cur[i];
      end
   endgenerate

   // increment; wraps naturally at the all-ones value
   assign bin_nxt = bin_cur + WIDTH'(1);

   // binary back to Gray
   assign gray_nxt[TOP] = bin_nxt[TOP];
   generate
      for (genvar i = 0; i < TOP; i++) begin : g_b2g
         assign gray_nxt[i] = bin_nxt[i+1] ^ bin_nxt[i];
      end
   endgenerate

   // R2
   one_bit_apart_chk: assert final ($countones(gray_nxt ^ gray_cur) == 1)
      else $error("next Gray code is not one bit away");
endmodule

// File: rtl/gcr_track.sv
module gcr_track #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] bus_word,
   input  logic [WIDTH-1:0] gray_nxt,
   input  logic [WIDTH-1:0] bin_nxt,
   output logic [WIDTH-1:0] gray_q,
   output logic [WIDTH-1:0] bin_q,
   output logic             step_q
);
   logic hit;

   assign hit = (bus_word == gray_nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gray_q <= '0;
         bin_q  <= '0;
         step_q <= 1'b0;
      end else begin
         step_q <= hit;
         if (hit) begin
            gray_q <= gray_nxt;
            bin_q  <= bin_nxt;
         end
      end
   end

   // R3
   hold_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(gray_q) && $stable(bin_q))
      else $error("state moved without a match");

   // R6
   change_has_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_q != $past(bin_q)) |-> step_q)
      else $error("count changed without a step pulse");

   // R7
   step_increments_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_q |-> (bin_q == WIDTH'($past(bin_q) + 1'b1)))
      else $error("step did not advance the count by one");

   // R2
   gray_single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_q |-> ($countones(gray_q ^ $past(gray_q)) == 1))
      else $error("accepted code differs in more than one bit");

   // R5
   gray_bin_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gray_q == (bin_q ^ (bin_q >> 1)))
      else $error("held Gray code and binary count disagree");

   // R6
   step_not_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_q |=> !step_q)
      else $error("two accepted steps in adjacent cycles");
endmodule

// File: rtl/gray_clock_rx.sv
module gray_clock_rx #(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] bus_gray,
   output logic [WIDTH-1:0] count_bin,
   output logic             bus_clk,
   output logic             step
);
   import gcr_pkg::*;

   generate
      if (WIDTH < GCR_MIN_WIDTH) begin : g_bad_width
         $error("gray_clock_rx: WIDTH below minimum");
      end
   endgenerate

   logic [WIDTH-1:0] bus_sync;
   logic [WIDTH-1:0] gray_hold;
   logic [WIDTH-1:0] gray_exp;
   logic [WIDTH-1:0] bin_exp;

   gcr_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (bus_gray),
      .sync_out (bus_sync)
   );

   gcr_next #(.WIDTH(WIDTH)) u_next (
      .gray_cur (gray_hold),
      .gray_nxt (gray_exp),
      .bin_nxt  (bin_exp)
   );

   gcr_track #(.WIDTH(WIDTH)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_word (bus_sync),
      .gray_nxt (gray_exp),
      .bin_nxt  (bin_exp),
      .gray_q   (gray_hold),
      .bin_q    (count_bin),
      .step_q   (step)
   );

   assign bus_clk = count_bin[0];

   // R1
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |=> (count_bin == '0) || !rst_n)
      else $error("count not zero after reset");
endmodule

// File: tb/gray_clock_rx_test.sv
`timescale 1ns/1ps
module gray_clock_rx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus4 = '0;
   logic [1:0] bus2 = '0;
   logic [3:0] cnt4;
   logic [1:0] cnt2;
   logic       bclk4, bclk2, stp4, stp2;

   int checks = 0;
   int errors = 0;
   int steps4 = 0;
   int steps2 = 0;

   always #4 clk = ~clk;

   gray_clock_rx #(.WIDTH(4), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .bus_gray(bus4),
      .count_bin(cnt4), .bus_clk(bclk4), .step(stp4));

   gray_clock_rx #(.WIDTH(2), .SYNC_STAGES(2)) uut_w2 (
      .clk(clk), .rst_n(rst_n), .bus_gray(bus2),
      .count_bin(cnt2), .bus_clk(bclk2), .step(stp2));

   always @(negedge clk) begin
      if (stp4) steps4++;
      if (stp2) steps2++;
   end

   function automatic int gray(int n);
      return n ^ (n >> 1);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive both buses to code n, verify latency, value, clock bit and pulse
   task automatic advance(input int n);
      int s4, s2, e4, e2;
      s4 = steps4; s2 = steps2;
      e4 = n % 16; e2 = n % 4;
      @(negedge clk);
      bus4 = 4'(gray(e4));
      bus2 = 2'(gray(e2));
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(cnt4 == 4'((n - 1) % 16), "R9", cnt4, (n - 1) % 16);
      @(posedge clk);
      @(negedge clk);
      check(cnt4 == 4'(e4), "R2", cnt4, e4);
      check(cnt2 == 2'(e2), "R8", cnt2, e2);
      check(bclk4 == cnt4[0] && bclk2 == cnt2[0], "R5", bclk4, cnt4[0]);
      if (e4 == 0) check(cnt4 == 4'd0, "R7", cnt4, 0);
      repeat (3) @(negedge clk);
      check(steps4 - s4 == 1 && steps2 - s2 == 1, "R6", steps4 - s4, 1);
   endtask

   // hold a wrong code on the wide bus and confirm nothing moves
   task automatic hold_wrong(input int code, input int cur, input string req);
      int s4;
      s4 = steps4;
      @(negedge clk);
      bus4 = 4'(code);
      repeat (6) @(negedge clk);
      check(cnt4 == 4'(cur), req, cnt4, cur);
      check(steps4 == s4, req, steps4 - s4, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(cnt4 == 0 && cnt2 == 0, "R1", cnt4, 0);
      check(bclk4 == 0 && stp4 == 0 && stp2 == 0, "R1", stp4, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(cnt4 == 0 && stp4 == 0, "R1", cnt4, 0);

      // full sweep: two wraps of the 4-wire bus, many of the 2-wire bus
      for (int n = 1; n <= 36; n++) advance(n);

      // count now 36 % 16 = 4
      hold_wrong(gray(3), 4, "R3");          // bounce to previous code
      hold_wrong(gray(4), 4, "R3");          // stay on current code
      hold_wrong(gray(6), 4, "R4");          // two steps ahead
      hold_wrong(gray(5) ^ 4'hF, 4, "R4");   // unrelated pattern
      hold_wrong(gray(3), 4, "R3");
      advance(37);                           // recovers onto 5

      // bounce sequence around each accept
      for (int n = 38; n <= 44; n++) begin
         advance(n);
         hold_wrong(gray((n - 1) % 16), n % 16, "R3");
         @(negedge clk);
         bus4 = 4'(gray(n % 16));
         repeat (4) @(negedge clk);
         check(cnt4 == 4'(n % 16), "R3", cnt4, n % 16);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule